// File: doc/BRIEF.md
# Interrupt Request Capture Unit

This block sits between the interrupt pins of a small processor subsystem and its instruction sequencer. It brings one non-maskable request and four maskable request lines into the core clock domain through synchronizer chains. Each maskable line can be set to edge or level sensitivity, and the block keeps each request pending in the form that setting calls for. At an instruction boundary it offers the core a single interrupt with a type number. The type stays on offer until the core acknowledges it.

The non-maskable source is edge sensitive, always wins arbitration, and ignores the global enable. The maskable sources are served only while the global enable is set, and always in fixed order, lowest line index first. The two highest request lines can each be turned into an active-low acknowledge output. When a line is used this way, its input is ignored, and the line pulses low for one cycle after the core acknowledges the matching low-numbered source.

A three-state controller does the sequencing. `ST_IDLE` waits for a boundary. The transition `take` (boundary with an eligible request) latches the winner and moves to `ST_PRESENT`. `ST_PRESENT` holds the offer. The transition `accept` (core acknowledge) clears the served edge and moves to `ST_ACK`. `ST_ACK` lasts one cycle, drives any acknowledge strobe, and returns to `ST_IDLE` through the transition `release`.

Top module: `irqc_capture`

## Requirements
- R1: After reset, `int_pending` is 0 and `ack_out_n` is 2'b11.
- R2: A low-to-high change on `nmi_req` is recorded as pending, but `int_pending` only rises in the cycle after a cycle in which `boundary` was high.
- R3: A recorded non-maskable request is offered with type 2 even when `int_enable` is 0.
- R4: When the non-maskable request and maskable requests are pending at the same boundary, type 2 is offered first.
- R5: Among pending maskable requests, the lowest line index is offered first, with type 12 + index (line 0 gives 12, line 3 gives 15).
- R6: While `int_enable` is 0, no maskable request is offered. A recorded edge stays pending and is offered once the enable is set.
- R7: In edge mode (`trig_level[i]`=0), a single-cycle high pulse is kept pending after the line falls. It is offered exactly once, and the core acknowledge clears it.
- R8: In level mode (`trig_level[i]`=1), the pending state follows the synchronized line. A line that drops before it is taken is not offered. A line that is still high after the acknowledge is offered again.
- R9: While `int_pending` is 1 and `core_ack` is 0, `int_pending` stays 1 and `int_type` is unchanged.
- R10: When `ack_mode[k]`=1, request line 2+k is ignored. `ack_out_n[k]` goes low for exactly the one cycle after the core accepts source k. When `ack_mode[k]`=0, `ack_out_n[k]` stays high.
- R11: Holding `nmi_req` high raises only one request. A further request needs a new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_req | input | 1 | Non-maskable request, asynchronous, rising-edge sensitive |
| irq_req | input | 4 | Maskable request lines, asynchronous, active high |
| trig_level | input | 4 | Per-line sensitivity: 1 = level, 0 = edge |
| ack_mode | input | 2 | Bit k set turns line 2+k into the acknowledge output for source k |
| int_enable | input | 1 | Global enable for maskable sources |
| boundary | input | 1 | Core is at an instruction boundary |
| core_ack | input | 1 | Core accepts the offered interrupt |
| int_pending | output | 1 | An interrupt is offered to the core |
| int_type | output | 8 | Type number of the offered interrupt |
| ack_out_n | output | 2 | Active-low acknowledge strobes for sources 0 and 1 |

## Verification
On every cycle, the assertions check that an offer begins only after a boundary and that a maskable offer begins only with the enable set. They also check that a held offer keeps its type until acknowledged, that a latched edge survives until cleared, and that the acknowledge strobes stay quiet unless their mode is selected. The bench scenarios show the things that need end-to-end sequences: the order of service across mixed sources, level lines that are withdrawn or re-offered, edges held across a disabled period, a single service for a held non-maskable line, and inputs that are ignored in acknowledge mode.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PRESENT = 2'd1,
        ST_ACK     = 2'd2
    } irqc_state_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= d;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] s,      // synchronized lines
    input  logic [N-1:0] level,  // 1 = level sensitive
    input  logic [N-1:0] dis,    // line ignored
    input  logic [N-1:0] clr,    // served edge clear
    output logic [N-1:0] pend
);
    logic [N-1:0] prev_q;
    logic [N-1:0] edge_q;

    for (genvar i = 0; i < N; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q[i] <= 1'b0;
                edge_q[i] <= 1'b0;
            end else begin
                prev_q[i] <= s[i];
                if (dis[i] || level[i])
                    edge_q[i] <= 1'b0;
                else if (s[i] && !prev_q[i])
                    edge_q[i] <= 1'b1;   // new edge wins over a clear
                else if (clr[i])
                    edge_q[i] <= 1'b0;
            end
        end

        always_comb begin
            if (dis[i])        pend[i] = 1'b0;
            else if (level[i]) pend[i] = s[i];
            else               pend[i] = edge_q[i];
        end

        // R7: a latched edge stays pending until cleared
        a_r7_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[i] && !level[i] && !dis[i] && !clr[i]) |=>
            (pend[i] || level[i] || dis[i]));

        // R7: a fresh synchronized rise in edge mode is recorded
        a_r7_edge_capture: assert property (@(posedge clk) disable iff (!rst_n)
            (s[i] && !prev_q[i] && !level[i] && !dis[i]) |=>
            (edge_q[i] || level[i] || dis[i]));
    end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int N         = 4,
    parameter int NUM_ACK   = 2,
    parameter int TYPE_W    = 8,
    parameter int NMI_TYPE  = 2,
    parameter int MASK_BASE = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boundary,
    input  logic               core_ack,
    input  logic               gie,
    input  logic               nmi_pend,
    input  logic [N-1:0]       irq_pend,
    input  logic [NUM_ACK-1:0] ack_mode,
    output logic               int_pending,
    output logic [TYPE_W-1:0]  int_type,
    output logic               clr_nmi,
    output logic [N-1:0]       clr_irq,
    output logic [NUM_ACK-1:0] ack_out_n
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    irqc_state_e      state_q, state_d;
    logic             sel_nmi_q;
    logic [IDX_W-1:0] sel_idx_q;
    logic             any_mask;
    logic [IDX_W-1:0] low_idx;
    logic             take;

    // fixed order: lowest index wins
    always_comb begin
        any_mask = 1'b0;
        low_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (irq_pend[i]) begin
                any_mask = 1'b1;
                low_idx  = IDX_W'(i);
            end
        end
    end

    assign take = boundary && (nmi_pend || (gie && any_mask));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (take)     state_d = ST_PRESENT;  // take
            ST_PRESENT: if (core_ack) state_d = ST_ACK;      // accept
            ST_ACK:                   state_d = ST_IDLE;     // release
            default:                  state_d = ST_IDLE;
        endcase
    end

    // state register and selection latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            sel_nmi_q <= 1'b0;
            sel_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && take) begin
                sel_nmi_q <= nmi_pend;
                sel_idx_q <= low_idx;
            end
        end
    end

    // outputs
    always_comb begin
        int_pending = (state_q == ST_PRESENT);
        int_type    = sel_nmi_q ? TYPE_W'(NMI_TYPE)
                                : TYPE_W'(MASK_BASE) + TYPE_W'(sel_idx_q);
        clr_nmi     = (state_q == ST_PRESENT) && core_ack && sel_nmi_q;
        clr_irq     = '0;
        if ((state_q == ST_PRESENT) && core_ack && !sel_nmi_q)
            clr_irq[sel_idx_q] = 1'b1;
        for (int k = 0; k < NUM_ACK; k++)
            ack_out_n[k] = !((state_q == ST_ACK) && !sel_nmi_q &&
                             (sel_idx_q == IDX_W'(k)) && ack_mode[k]);
    end

    // R2: an offer only begins after a boundary
    a_r2_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_pending) |-> $past(boundary));

    // R4: non-maskable wins when taken together
    a_r4_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && boundary && nmi_pend) |=>
        (int_pending && int_type == TYPE_W'(NMI_TYPE)));

    // R9: held offer keeps its type
    a_r9_type_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (int_pending && !core_ack) |=> (int_pending && $stable(int_type)));

    // R10: at most one strobe at a time
    a_r10_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ack_out_n));

    for (genvar k = 0; k < NUM_ACK; k++) begin : g_ackchk
        // R10: strobe silent when line is a plain input
        a_r10_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !ack_mode[k] |-> ack_out_n[k]);
    end
endmodule

// File: rtl/irqc_capture.sv
module irqc_capture #(
    parameter int N_IRQ     = 4,
    parameter int N_ACK     = 2,
    parameter int SYNC_LEN  = 2,
    parameter int TYPE_W    = 8,
    parameter int NMI_TYPE  = 2,
    parameter int MASK_BASE = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_req,
    input  logic [N_IRQ-1:0]  irq_req,
    input  logic [N_IRQ-1:0]  trig_level,
    input  logic [N_ACK-1:0]  ack_mode,
    input  logic              int_enable,
    input  logic              boundary,
    input  logic              core_ack,
    output logic              int_pending,
    output logic [TYPE_W-1:0] int_type,
    output logic [N_ACK-1:0]  ack_out_n
);
    localparam int FIRST_ACK_LINE = N_IRQ - N_ACK;

    logic             nmi_s;
    logic [N_IRQ-1:0] irq_s;
    logic             nmi_pend;
    logic [N_IRQ-1:0] irq_pend;
    logic             clr_nmi;
    logic [N_IRQ-1:0] clr_irq;
    logic [N_IRQ-1:0] line_dis;

    always_comb begin
        line_dis = '0;
        for (int k = 0; k < N_ACK; k++)
            line_dis[FIRST_ACK_LINE + k] = ack_mode[k];
    end

    irqc_sync #(.WIDTH(1), .STAGES(SYNC_LEN)) u_nmi_sync (
        .clk(clk), .rst_n(rst_n), .d(nmi_req), .q(nmi_s));

    irqc_sync #(.WIDTH(N_IRQ), .STAGES(SYNC_LEN)) u_irq_sync (
        .clk(clk), .rst_n(rst_n), .d(irq_req), .q(irq_s));

    irqc_detect #(.N(1)) u_nmi_det (
        .clk(clk), .rst_n(rst_n), .s(nmi_s), .level(1'b0), .dis(1'b0),
        .clr(clr_nmi), .pend(nmi_pend));

    irqc_detect #(.N(N_IRQ)) u_irq_det (
        .clk(clk), .rst_n(rst_n), .s(irq_s), .level(trig_level), .dis(line_dis),
        .clr(clr_irq), .pend(irq_pend));

    irqc_arbiter #(
        .N(N_IRQ), .NUM_ACK(N_ACK), .TYPE_W(TYPE_W),
        .NMI_TYPE(NMI_TYPE), .MASK_BASE(MASK_BASE)
    ) u_arb (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .core_ack(core_ack),
        .gie(int_enable), .nmi_pend(nmi_pend), .irq_pend(irq_pend),
        .ack_mode(ack_mode), .int_pending(int_pending), .int_type(int_type),
        .clr_nmi(clr_nmi), .clr_irq(clr_irq), .ack_out_n(ack_out_n));

    // R6: a maskable offer only begins with the enable set
    a_r6_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(int_pending) && int_type != TYPE_W'(NMI_TYPE)) |-> $past(int_enable));

    // R3: the non-maskable latch is never lost without service
    a_r3_nmi_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && !clr_nmi) |=> nmi_pend);
endmodule

// File: tb/test_irqc_capture.sv
module test_irqc_capture;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nmi_req = 1'b0;
    logic [3:0] irq_req = '0;
    logic [3:0] trig_level = '0;
    logic [1:0] ack_mode = '0;
    logic       int_enable = 1'b0;
    logic       boundary = 1'b0;
    logic       core_ack = 1'b0;
    logic       int_pending;
    logic [7:0] int_type;
    logic [1:0] ack_out_n;

    int tests = 0;
    int fails = 0;
    int exp_q[$];
    logic mon_prev = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    irqc_capture i_irqc_capture (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .irq_req(irq_req),
        .trig_level(trig_level), .ack_mode(ack_mode), .int_enable(int_enable),
        .boundary(boundary), .core_ack(core_ack), .int_pending(int_pending),
        .int_type(int_type), .ack_out_n(ack_out_n));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pop the expected type at each new offer
    always @(negedge clk) begin
        if (rst_n && int_pending && !mon_prev) begin
            if (exp_q.size() == 0)
                check(1'b0, "R2/R6 unexpected offer", int_type, -1);
            else begin
                int e;
                e = exp_q.pop_front();
                check(int_type == 8'(e), "R5 offered type", int_type, e);
            end
        end
        mon_prev = int_pending;
    end

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_irq(input int line);
        @(negedge clk) irq_req[line] = 1'b1;
        @(negedge clk) irq_req[line] = 1'b0;
        settle();
    endtask

    task automatic pulse_nmi();
        @(negedge clk) nmi_req = 1'b1;
        @(negedge clk) nmi_req = 1'b0;
        settle();
    endtask

    // driver: push expectation, raise boundary, accept
    task automatic serve(input int exp_type, input logic [1:0] exp_ack, input string tag);
        int waited = 0;
        exp_q.push_back(exp_type);
        @(negedge clk) boundary = 1'b1;
        @(negedge clk);
        while (!int_pending && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        check(int_pending, {tag, " offer seen"}, int_pending, 1);
        @(negedge clk);
        @(negedge clk);
        // R9: held without acknowledge
        check(int_pending && int_type == 8'(exp_type), "R9 held offer", int_type, exp_type);
        core_ack = 1'b1;
        @(negedge clk);
        core_ack = 1'b0;
        boundary = 1'b0;
        check(ack_out_n == exp_ack, "R10 ack strobe", ack_out_n, exp_ack);
        @(negedge clk);
        check(ack_out_n == 2'b11, "R10 strobe one cycle", ack_out_n, 3);
    endtask

    task automatic expect_none(input string tag);
        bit seen = 1'b0;
        @(negedge clk) boundary = 1'b1;
        repeat (6) begin
            @(negedge clk);
            if (int_pending) seen = 1'b1;
        end
        boundary = 1'b0;
        check(!seen, tag, seen, 0);
        if (seen) begin
            core_ack = 1'b1;
            @(negedge clk) core_ack = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check(int_pending == 1'b0, "R1 pending at reset", int_pending, 0);
        check(ack_out_n == 2'b11, "R1 ack at reset", ack_out_n, 3);
        rst_n = 1'b1;
        settle();

        // R2: no offer before a boundary
        pulse_nmi();
        repeat (4) @(negedge clk);
        check(!int_pending, "R2 waits for boundary", int_pending, 0);
        // R3: served with enable off
        serve(2, 2'b11, "R3");

        // R11: held high raises one request only
        @(negedge clk) nmi_req = 1'b1;
        settle();
        serve(2, 2'b11, "R11");
        expect_none("R11 no retrigger");
        @(negedge clk) nmi_req = 1'b0;
        settle();

        // R6 / R7: edge held across disabled period, offered once
        pulse_irq(0);
        expect_none("R6 blocked while disabled");
        int_enable = 1'b1;
        serve(12, 2'b11, "R6");
        expect_none("R7 offered once");

        // R4 / R5: mixed sources
        @(negedge clk) begin irq_req[3] = 1'b1; irq_req[1] = 1'b1; nmi_req = 1'b1; end
        @(negedge clk) begin irq_req = '0; nmi_req = 1'b0; end
        settle();
        serve(2, 2'b11, "R4");
        serve(13, 2'b11, "R5 line1");
        serve(15, 2'b11, "R5 line3");
        expect_none("R5 all drained");

        // R8: level mode
        trig_level = 4'b0010;
        @(negedge clk) irq_req[1] = 1'b1;
        settle();
        serve(13, 2'b11, "R8 first");
        serve(13, 2'b11, "R8 re-offer");
        @(negedge clk) irq_req[1] = 1'b0;
        settle();
        expect_none("R8 withdrawn");
        @(negedge clk) irq_req[1] = 1'b1;
        @(negedge clk) irq_req[1] = 1'b0;
        settle();
        expect_none("R8 short level dropped");
        trig_level = '0;

        // R10: line 2 as acknowledge output
        ack_mode = 2'b01;
        settle();
        pulse_irq(2);
        expect_none("R10 line ignored");
        pulse_irq(0);
        serve(12, 2'b10, "R10 source0");
        pulse_irq(1);
        serve(13, 2'b11, "R10 source1 no strobe");
        ack_mode = 2'b10;
        settle();
        pulse_irq(1);
        serve(13, 2'b01, "R10 source1 strobe");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule